// File: doc/BRIEF.md
# MII Port Loopback and Isolation Controller

This block sits between the data pins of an external MAC and one port of an internal switch engine, with the block taking the PHY role toward the MAC. In normal operation it passes MAC transmit data and enable to the switch receive side, and switch transmit data and enable to the MAC receive side. It also generates collision and carrier sense for both sides from the two transmit enables.

Two loopback directions can be selected on their own. MAC loopback returns the MAC's transmit stream to the MAC receive pins. Switch loopback returns the switch's transmit stream to the switch receive side. Each direction has its own collision-test bit. When both loopbacks are set, each side takes its own loopback.

Isolation turns off the MAC-side output enable and forces the MAC inputs inactive. Switch loopback keeps working while isolation is set. A configurable SQE heartbeat pulse appears on the MAC collision output after each MAC transmission. A reduced-pin (RMII) flag narrows the data path to two bits, blocks the heartbeat and blocks MAC collision testing. All outputs are registered on the port clock.

Top module: `mii_lpbk_ctrl`

## Requirements
- R1: While `rst_n` is low, every output is 0, and that includes `mac_oe`.
- R2: Every output reflects the control and input values sampled at the preceding rising clock edge, so there is one cycle of latency. With no loopback set, `sw_rxd`/`sw_rxdv` carry the MAC transmit data/enable and `mac_rxd`/`mac_rxdv` carry the switch transmit data/enable.
- R3: With no loopback set, `mac_crs` and `sw_crs` are the OR of the two transmit enables. `sw_col` is the AND of the two enables. `mac_col` is that AND ORed with the heartbeat.
- R4: In MAC loopback (when switch loopback is clear), `mac_rxd`/`mac_rxdv` return the MAC transmit data/enable and `mac_crs` equals the MAC transmit enable. `sw_rxd`, `sw_rxdv`, `sw_col` and `sw_crs` are all 0.
- R5: In MAC loopback, `mac_col` equals `cfg_mac_col_test` AND the MAC transmit enable, and the heartbeat never appears on `mac_col`.
- R6: In switch loopback, `sw_rxd`/`sw_rxdv` return the switch transmit data/enable, `sw_crs` equals the switch enable, and `sw_col` equals `cfg_sw_col_test` AND the switch enable. If MAC loopback is clear, `mac_rxd`/`mac_rxdv` are 0, `mac_crs` equals the MAC enable, and `mac_col` carries only the heartbeat.
- R7: With both loopbacks set, the MAC side follows R4/R5 and the switch side follows R6, each independently.
- R8: With `cfg_isolate` set, `mac_oe` is 0 and `mac_txd`/`mac_txen` are treated as 0. Switch loopback behaves exactly as without isolation.
- R9: When the MAC transmit enable is first sampled low after being high, `mac_col` goes high for SQE_LEN cycles. It rises at the (SQE_DLY+1)-th sample after that edge. There is no pulse if `cfg_sqe_off` is set or MAC loopback is set.
- R10: With `cfg_rmii` set, data bits above bit 1 of `mac_rxd` and `sw_rxd` are 0, no heartbeat is produced, and `cfg_mac_col_test` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_mac_lpbk | input | 1 | MAC loopback select |
| cfg_sw_lpbk | input | 1 | Switch loopback select |
| cfg_isolate | input | 1 | MAC-side isolation |
| cfg_mac_col_test | input | 1 | Collision test toward MAC in MAC loopback |
| cfg_sw_col_test | input | 1 | Collision test toward switch in switch loopback |
| cfg_sqe_off | input | 1 | Heartbeat disable |
| cfg_rmii | input | 1 | Reduced-pin mode flag |
| mac_txd | input | DATA_W | Transmit data from MAC |
| mac_txen | input | 1 | Transmit enable from MAC |
| mac_rxd | output | DATA_W | Receive data to MAC |
| mac_rxdv | output | 1 | Receive data valid to MAC |
| mac_col | output | 1 | Collision to MAC |
| mac_crs | output | 1 | Carrier sense to MAC |
| mac_oe | output | 1 | Output enable of MAC-side data pins |
| sw_txd | input | DATA_W | Transmit data from switch |
| sw_txen | input | 1 | Transmit enable from switch |
| sw_rxd | output | DATA_W | Receive data to switch |
| sw_rxdv | output | 1 | Receive data valid to switch |
| sw_col | output | 1 | Collision to switch |
| sw_crs | output | 1 | Carrier sense to switch |

## Verification
The only internal state is the heartbeat sequencer and the sampled MAC enable. A wrong count or a missed edge shows on `mac_col` within SQE_DLY+SQE_LEN+1 cycles of the enable falling: the pulse is early, late, the wrong length, or missing. Routing errors carry no state, so a bad route, mask or gate shows on the very next sample of the affected output. The sweep visits every control combination with each pair of transmit enables, so every route is observed once.

// File: rtl/mii_lpbk_pkg.sv
package mii_lpbk_pkg;

   typedef struct packed {
      logic mac_lpbk;
      logic sw_lpbk;
      logic isolate;
      logic mac_col_test;
      logic sw_col_test;
      logic sqe_off;
      logic rmii;
   } lp_cfg_t;

   typedef enum logic [1:0] {
      SQE_IDLE  = 2'd0,
      SQE_WAIT  = 2'd1,
      SQE_PULSE = 2'd2
   } sqe_st_t;

   localparam int RMII_BITS = 2;

endpackage

// File: rtl/mii_in_gate.sv
module mii_in_gate #(
   parameter int DATA_W = 4
) (
   input  logic              force_idle,
   input  logic              rmii,
   input  logic [DATA_W-1:0] txd,
   input  logic              txen,
   output logic [DATA_W-1:0] txd_g,
   output logic              txen_g
);
   import mii_lpbk_pkg::*;

   localparam int LOW_W = (DATA_W < RMII_BITS) ? DATA_W : RMII_BITS;

   assign txen_g = txen & ~force_idle;

   assign txd_g[LOW_W-1:0] = force_idle ? '0 : txd[LOW_W-1:0];

   generate
      if (DATA_W > RMII_BITS) begin : g_upper
         assign txd_g[DATA_W-1:LOW_W] = (force_idle | rmii) ? '0 : txd[DATA_W-1:LOW_W];
      end
   endgenerate

endmodule

// File: rtl/mii_sqe_gen.sv
module mii_sqe_gen #(
   parameter int SQE_DLY = 4,
   parameter int SQE_LEN = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic txen,
   output logic sqe
);
   import mii_lpbk_pkg::*;

   localparam int MAXC = (SQE_DLY > SQE_LEN) ? SQE_DLY : SQE_LEN;
   localparam int CW   = $clog2(MAXC + 1);
   localparam logic [CW-1:0] DLY_END = CW'(SQE_DLY - 1);
   localparam logic [CW-1:0] LEN_END = CW'(SQE_LEN - 1);

   sqe_st_t       st;
   logic [CW-1:0] cnt;
   logic          txen_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st     <= SQE_IDLE;
         cnt    <= '0;
         txen_q <= 1'b0;
      end else begin
         txen_q <= txen;
         case (st)
            SQE_IDLE: begin
               if (en && txen_q && !txen) begin
                  st  <= SQE_WAIT;
                  cnt <= '0;
               end
            end
            SQE_WAIT: begin
               if (txen) begin
                  st <= SQE_IDLE;
               end else if (cnt == DLY_END) begin
                  st  <= SQE_PULSE;
                  cnt <= '0;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            SQE_PULSE: begin
               if (txen || cnt == LEN_END) begin
                  st  <= SQE_IDLE;
                  cnt <= '0;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            default: st <= SQE_IDLE;
         endcase
      end
   end

   assign sqe = (st == SQE_PULSE) & en;

endmodule

// File: rtl/mii_route.sv
module mii_route #(
   parameter int DATA_W = 4
) (
   input  mii_lpbk_pkg::lp_cfg_t cfg,
   input  logic [DATA_W-1:0]     m_txd,
   input  logic                  m_en,
   input  logic [DATA_W-1:0]     s_txd,
   input  logic                  s_en,
   input  logic                  sqe,
   output logic [DATA_W-1:0]     m_rxd,
   output logic                  m_rxdv,
   output logic                  m_col,
   output logic                  m_crs,
   output logic [DATA_W-1:0]     s_rxd,
   output logic                  s_rxdv,
   output logic                  s_col,
   output logic                  s_crs
);

   logic both_en;
   assign both_en = m_en & s_en;

   // MAC-facing side
   always_comb begin
      if (cfg.mac_lpbk) begin
         m_rxd  = m_txd;
         m_rxdv = m_en;
         m_crs  = m_en;
         m_col  = cfg.mac_col_test & ~cfg.rmii & m_en;
      end else if (cfg.sw_lpbk) begin
         m_rxd  = '0;
         m_rxdv = 1'b0;
         m_crs  = m_en;
         m_col  = sqe;
      end else begin
         m_rxd  = s_txd;
         m_rxdv = s_en;
         m_crs  = m_en | s_en;
         m_col  = both_en | sqe;
      end
   end

   // Switch-facing side
   always_comb begin
      if (cfg.sw_lpbk) begin
         s_rxd  = s_txd;
         s_rxdv = s_en;
         s_crs  = s_en;
         s_col  = cfg.sw_col_test & s_en;
      end else if (cfg.mac_lpbk) begin
         s_rxd  = '0;
         s_rxdv = 1'b0;
         s_crs  = 1'b0;
         s_col  = 1'b0;
      end else begin
         s_rxd  = m_txd;
         s_rxdv = m_en;
         s_crs  = m_en | s_en;
         s_col  = both_en;
      end
   end

endmodule

// File: rtl/mii_lpbk_ctrl.sv
module mii_lpbk_ctrl #(
   parameter int DATA_W  = 4,
   parameter int SQE_DLY = 4,
   parameter int SQE_LEN = 3,
   parameter bit HAS_SQE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_mac_lpbk,
   input  logic              cfg_sw_lpbk,
   input  logic              cfg_isolate,
   input  logic              cfg_mac_col_test,
   input  logic              cfg_sw_col_test,
   input  logic              cfg_sqe_off,
   input  logic              cfg_rmii,
   input  logic [DATA_W-1:0] mac_txd,
   input  logic              mac_txen,
   output logic [DATA_W-1:0] mac_rxd,
   output logic              mac_rxdv,
   output logic              mac_col,
   output logic              mac_crs,
   output logic              mac_oe,
   input  logic [DATA_W-1:0] sw_txd,
   input  logic              sw_txen,
   output logic [DATA_W-1:0] sw_rxd,
   output logic              sw_rxdv,
   output logic              sw_col,
   output logic              sw_crs
);
   import mii_lpbk_pkg::*;

   generate
      if (DATA_W < RMII_BITS) begin : g_bad_w
         $error("DATA_W must be at least 2");
      end
      if (SQE_DLY < 1) begin : g_bad_dly
         $error("SQE_DLY must be at least 1");
      end
      if (SQE_LEN < 1) begin : g_bad_len
         $error("SQE_LEN must be at least 1");
      end
   endgenerate

   lp_cfg_t cfg;
   assign cfg = '{mac_lpbk:     cfg_mac_lpbk,
                  sw_lpbk:      cfg_sw_lpbk,
                  isolate:      cfg_isolate,
                  mac_col_test: cfg_mac_col_test,
                  sw_col_test:  cfg_sw_col_test,
                  sqe_off:      cfg_sqe_off,
                  rmii:         cfg_rmii};

   logic [DATA_W-1:0] m_txd_g, s_txd_g;
   logic              m_en_g, s_en_g;

   mii_in_gate #(.DATA_W(DATA_W)) u_gate_mac (
      .force_idle (cfg.isolate),
      .rmii       (cfg.rmii),
      .txd        (mac_txd),
      .txen       (mac_txen),
      .txd_g      (m_txd_g),
      .txen_g     (m_en_g)
   );

   mii_in_gate #(.DATA_W(DATA_W)) u_gate_sw (
      .force_idle (1'b0),
      .rmii       (cfg.rmii),
      .txd        (sw_txd),
      .txen       (sw_txen),
      .txd_g      (s_txd_g),
      .txen_g     (s_en_g)
   );

   logic sqe_en, sqe;
   assign sqe_en = ~cfg.sqe_off & ~cfg.rmii & ~cfg.mac_lpbk;

   generate
      if (HAS_SQE) begin : g_sqe
         mii_sqe_gen #(.SQE_DLY(SQE_DLY), .SQE_LEN(SQE_LEN)) u_sqe (
            .clk   (clk),
            .rst_n (rst_n),
            .en    (sqe_en),
            .txen  (m_en_g),
            .sqe   (sqe)
         );
      end else begin : g_no_sqe
         assign sqe = 1'b0;
      end
   endgenerate

   logic [DATA_W-1:0] m_rxd_d, s_rxd_d;
   logic              m_rxdv_d, m_col_d, m_crs_d;
   logic              s_rxdv_d, s_col_d, s_crs_d;

   mii_route #(.DATA_W(DATA_W)) u_route (
      .cfg    (cfg),
      .m_txd  (m_txd_g),
      .m_en   (m_en_g),
      .s_txd  (s_txd_g),
      .s_en   (s_en_g),
      .sqe    (sqe),
      .m_rxd  (m_rxd_d),
      .m_rxdv (m_rxdv_d),
      .m_col  (m_col_d),
      .m_crs  (m_crs_d),
      .s_rxd  (s_rxd_d),
      .s_rxdv (s_rxdv_d),
      .s_col  (s_col_d),
      .s_crs  (s_crs_d)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mac_rxd  <= '0;
         mac_rxdv <= 1'b0;
         mac_col  <= 1'b0;
         mac_crs  <= 1'b0;
         mac_oe   <= 1'b0;
         sw_rxd   <= '0;
         sw_rxdv  <= 1'b0;
         sw_col   <= 1'b0;
         sw_crs   <= 1'b0;
      end else begin
         mac_rxd  <= m_rxd_d;
         mac_rxdv <= m_rxdv_d;
         mac_col  <= m_col_d;
         mac_crs  <= m_crs_d;
         mac_oe   <= ~cfg.isolate;
         sw_rxd   <= s_rxd_d;
         sw_rxdv  <= s_rxdv_d;
         sw_col   <= s_col_d;
         sw_crs   <= s_crs_d;
      end
   end

endmodule

// File: rtl/mii_lpbk_ctrl_chk.sv
module mii_lpbk_ctrl_chk #(
   parameter int DATA_W = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cfg_mac_lpbk,
   input logic              cfg_sw_lpbk,
   input logic              cfg_isolate,
   input logic              cfg_mac_col_test,
   input logic              cfg_sw_col_test,
   input logic              cfg_rmii,
   input logic [DATA_W-1:0] mac_txd,
   input logic              mac_txen,
   input logic [DATA_W-1:0] mac_rxd,
   input logic              mac_rxdv,
   input logic              mac_col,
   input logic              mac_crs,
   input logic              mac_oe,
   input logic              sw_txen,
   input logic [DATA_W-1:0] sw_rxd,
   input logic              sw_rxdv,
   input logic              sw_col,
   input logic              sw_crs
);

   AST_RESET_QUIET: assert property (@(posedge clk)
      !rst_n |-> (!mac_oe && !mac_col && !sw_col && !mac_rxdv && !sw_rxdv)); // R1

   AST_NORMAL_FWD: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_mac_lpbk && !cfg_sw_lpbk && !cfg_isolate && !cfg_rmii)
      |=> (sw_rxd == $past(mac_txd) && sw_rxdv == $past(mac_txen))); // R2

   AST_NORMAL_CRS: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_mac_lpbk && !cfg_sw_lpbk && !cfg_isolate)
      |=> (mac_crs == $past(mac_txen || sw_txen))); // R3

   AST_MACLP_SW_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_mac_lpbk && !cfg_sw_lpbk) |=> (!sw_rxdv && !sw_crs && !sw_col)); // R4

   AST_MACLP_NO_SQE: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_mac_lpbk && !cfg_mac_col_test) |=> !mac_col); // R5

   AST_SWLP_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_sw_lpbk |=> (sw_rxdv == $past(sw_txen) && sw_crs == $past(sw_txen)
                       && sw_col == $past(cfg_sw_col_test && sw_txen))); // R6

   AST_BOTH_LP_MAC: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_mac_lpbk && cfg_sw_lpbk && !cfg_isolate)
      |=> (mac_rxdv == $past(mac_txen))); // R7

   AST_ISO_OE: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_isolate |=> !mac_oe); // R8

   AST_RMII_NARROW: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_rmii |=> ((mac_rxd >> 2) == '0 && (sw_rxd >> 2) == '0)); // R10

endmodule

bind mii_lpbk_ctrl mii_lpbk_ctrl_chk #(.DATA_W(DATA_W)) u_chk (
   .clk              (clk),
   .rst_n            (rst_n),
   .cfg_mac_lpbk     (cfg_mac_lpbk),
   .cfg_sw_lpbk      (cfg_sw_lpbk),
   .cfg_isolate      (cfg_isolate),
   .cfg_mac_col_test (cfg_mac_col_test),
   .cfg_sw_col_test  (cfg_sw_col_test),
   .cfg_rmii         (cfg_rmii),
   .mac_txd          (mac_txd),
   .mac_txen         (mac_txen),
   .mac_rxd          (mac_rxd),
   .mac_rxdv         (mac_rxdv),
   .mac_col          (mac_col),
   .mac_crs          (mac_crs),
   .mac_oe           (mac_oe),
   .sw_txen          (sw_txen),
   .sw_rxd           (sw_rxd),
   .sw_rxdv          (sw_rxdv),
   .sw_col           (sw_col),
   .sw_crs           (sw_crs)
);

// File: tb/test_mii_lpbk_ctrl.sv
module test_mii_lpbk_ctrl;

   localparam int DW  = 4;
   localparam int DLY = 3;
   localparam int LEN = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic c_mlp = 0, c_slp = 0, c_iso = 0, c_mct = 0, c_sct = 0, c_sqo = 0, c_rmii = 0;
   logic [DW-1:0] mac_txd = '0, sw_txd = '0;
   logic mac_txen = 0, sw_txen = 0;
   logic [DW-1:0] mac_rxd, sw_rxd;
   logic mac_rxdv, mac_col, mac_crs, mac_oe, sw_rxdv, sw_col, sw_crs;

   int checks = 0;
   int fails  = 0;

   always #2.5 clk = ~clk;

   mii_lpbk_ctrl #(.DATA_W(DW), .SQE_DLY(DLY), .SQE_LEN(LEN), .HAS_SQE(1'b1)) i_mii_lpbk_ctrl (
      .clk(clk), .rst_n(rst_n),
      .cfg_mac_lpbk(c_mlp), .cfg_sw_lpbk(c_slp), .cfg_isolate(c_iso),
      .cfg_mac_col_test(c_mct), .cfg_sw_col_test(c_sct), .cfg_sqe_off(c_sqo), .cfg_rmii(c_rmii),
      .mac_txd(mac_txd), .mac_txen(mac_txen), .mac_rxd(mac_rxd), .mac_rxdv(mac_rxdv),
      .mac_col(mac_col), .mac_crs(mac_crs), .mac_oe(mac_oe),
      .sw_txd(sw_txd), .sw_txen(sw_txen), .sw_rxd(sw_rxd), .sw_rxdv(sw_rxdv),
      .sw_col(sw_col), .sw_crs(sw_crs)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   function automatic string tag_of(input logic [6:0] c);
      if (c[2])             return "R8";
      if (c[0] && c[1])     return "R7";
      if (c[0])             return "R4 R5";
      if (c[1])             return "R6";
      if (c[6])             return "R10";
      return "R2 R3";
   endfunction

   // c: {rmii, sqe_off, sw_col_test, mac_col_test, isolate, sw_lpbk, mac_lpbk} as bits 6..0
   function automatic logic [31:0] expect_vec(input logic [6:0] c,
                                               input logic [DW-1:0] mtd, input logic men_i,
                                               input logic [DW-1:0] std_i, input logic sen);
      logic [DW-1:0] msk, mtx, stx, mrx, srx;
      logic men, mrv, mcl, mcs, srv, scl, scs;
      msk = c[6] ? DW'(3) : {DW{1'b1}};
      mtx = c[2] ? '0 : (mtd & msk);
      men = c[2] ? 1'b0 : men_i;
      stx = std_i & msk;
      if (c[0]) begin
         mrx = mtx; mrv = men; mcs = men; mcl = c[3] & ~c[6] & men;
      end else if (c[1]) begin
         mrx = '0; mrv = 0; mcs = men; mcl = 0;
      end else begin
         mrx = stx; mrv = sen; mcs = men | sen; mcl = men & sen;
      end
      if (c[1]) begin
         srx = stx; srv = sen; scs = sen; scl = c[4] & sen;
      end else if (c[0]) begin
         srx = '0; srv = 0; scs = 0; scl = 0;
      end else begin
         srx = mtx; srv = men; scs = men | sen; scl = men & sen;
      end
      return {15'd0, ~c[2], mrx, mrv, mcl, mcs, srx, srv, scl, scs};
   endfunction

   function automatic logic [31:0] actual_vec();
      return {15'd0, mac_oe, mac_rxd, mac_rxdv, mac_col, mac_crs, sw_rxd, sw_rxdv, sw_col, sw_crs};
   endfunction

   task automatic set_cfg(input logic [6:0] c);
      {c_rmii, c_sqo, c_sct, c_mct, c_iso, c_slp, c_mlp} = c;
   endtask

   task automatic idle_wait(input int n);
      mac_txen = 0; sw_txen = 0;
      repeat (n) @(negedge clk);
   endtask

   task automatic sqe_run(input logic [6:0] c, input bit want, input string tag);
      set_cfg(c);
      idle_wait(DLY + LEN + 4);
      mac_txen = 1;
      repeat (3) @(negedge clk);
      mac_txen = 0;
      for (int n = 0; n <= DLY + LEN + 3; n++) begin
         @(negedge clk);
         check(tag, mac_col, (want && n >= DLY + 1 && n <= DLY + LEN));
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      check("R1", actual_vec(), 32'd0);
      rst_n = 1;
      @(negedge clk);

      // exhaustive sweep over controls and transmit enables (R2..R8, R10)
      for (int ci = 0; ci < 128; ci++) begin
         for (int ei = 0; ei < 4; ei++) begin
            idle_wait(DLY + LEN + 3);
            set_cfg(ci[6:0]);
            mac_txd  = DW'(ci * 3 + ei * 7 + 5);
            sw_txd   = DW'(ci * 5 + ei * 11 + 10);
            mac_txen = ei[0];
            sw_txen  = ei[1];
            @(negedge clk);
            check(tag_of(ci[6:0]), actual_vec(),
                  expect_vec(ci[6:0], mac_txd, mac_txen, sw_txd, sw_txen));
         end
      end

      // heartbeat timing and suppression
      sqe_run(7'b0000000, 1'b1, "R9 normal");
      sqe_run(7'b0100000, 1'b0, "R9 sqe_off");
      sqe_run(7'b1000000, 1'b0, "R10 rmii");
      sqe_run(7'b0000001, 1'b0, "R5 mac loopback");
      sqe_run(7'b0000010, 1'b1, "R6 switch loopback");
      sqe_run(7'b0000100, 1'b0, "R8 isolate");

      idle_wait(2);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule